// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage of a pipelined core and proposes the next fetch address each cycle. It holds two direct-mapped tables addressed by the low word-address bits of the PC. The first table holds a 2-bit saturating confidence counter per slot. The second table caches branch destinations, and each of its slots carries a valid flag and the upper PC bits as a tag. The lookup is purely combinational. The fetch stage presents `fetch_pc` and reads `pred_npc` in the same cycle. Fetch is redirected to the cached destination only when the cache slot matches and its counter leans taken. In every other case fetch falls through to the next sequential word.

When the core resolves a branch, it drives the resolution port for one cycle. The port carries the branch address, whether the branch was taken, its real destination, and the next address that was predicted for it at fetch time. The counter for that slot moves one step toward the outcome. A taken branch also installs its destination and tag in the cache. In the same cycle the block flags `mispredict` when the predicted next address differs from the real one, so the core can flush the younger instructions.

The resolution port is a valid-qualified strobe, and the block never back-pressures it: it accepts a resolution in every cycle in which `upd_valid` is high. Resolution data is not transported anywhere else, so the port needs no ready signal. Tables are written only on the clock edge. A lookup in the same cycle as an update therefore sees the contents from before that update.

Top module: `branch_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and every cache slot is invalid, so `pred_npc` equals `fetch_pc + 4` for every PC.
- R2: Counter values 00 and 01 predict not taken, and 10 and 11 predict taken. A taken resolution increments the counter, saturating at 11. A not-taken resolution decrements it, saturating at 00.
- R3: A counter at 11 still predicts taken after a single not-taken resolution. The prediction flips only after a second consecutive one.
- R4: A cache slot hits only if it is valid and its stored tag equals `fetch_pc[PC_W-1:IDX_W+2]`. On a tag mismatch the prediction is `fetch_pc + 4`.
- R5: When the cache hits and the counter predicts taken, `pred_npc` is the stored destination. Otherwise `pred_npc` is `fetch_pc + 4`.
- R6: A taken resolution writes the real destination and the tag of `upd_pc` into the slot at `upd_pc[IDX_W+1:2]` and marks it valid. A not-taken resolution leaves the cache slot unchanged.
- R7: `mispredict` is high exactly when `upd_valid` is high and `upd_pred_npc` differs from the real next address. The real next address is `upd_target` if the branch was taken and `upd_pc + 4` if not. This covers both a wrong direction and a wrong destination.
- R8: When a lookup and an update hit the same slot in one cycle, the lookup returns the contents from before the update.
- R9: While `upd_valid` is low, no counter and no cache slot changes, whatever the other resolution inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_npc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | Resolution strobe, accepted every cycle it is high |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_target | input | PC_W | Real destination of the resolved branch |
| upd_pred_npc | input | PC_W | Next address that was predicted for this branch at fetch |
| mispredict | output | 1 | Predicted and real next address differ; flush request |

## Verification
The bench builds the block with `IDX_W = 3`, which gives eight slots, and keeps the 32-bit PC. It draws branch addresses from two address regions whose low bits coincide. Every slot is therefore shared by two tags, and tag mismatch, slot replacement and counter saturation each occur many times within a few thousand cycles. Half of the resolutions replay the bench's own prediction, so both the agreeing and the flushing outcomes of the resolution port are exercised.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] conf_t;

  localparam conf_t CONF_RESET = 2'b01;
  localparam conf_t CONF_MAX   = 2'b11;
  localparam conf_t CONF_MIN   = 2'b00;

  // The upper counter bit carries the direction guess.
  function automatic logic conf_says_taken(conf_t c);
    return c[1];
  endfunction

  function automatic conf_t conf_step(conf_t c, logic taken);
    conf_t n;
    n = c;
    if (taken && c != CONF_MAX) n = c + 2'd1;
    else if (!taken && c != CONF_MIN) n = c - 2'd1;
    return n;
  endfunction
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  conf_t [ENTRIES-1:0] conf_q;
  logic  [ENTRIES-1:0] slot_we;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_we
    assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) conf_q[i] <= CONF_RESET;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (slot_we[i]) conf_q[i] <= conf_step(conf_q[i], wr_taken);
    end
  end

  assign rd_taken = conf_says_taken(conf_q[rd_idx]);

  // R2: a taken resolution never lowers the counter
  a_r2_up_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken) |=> (conf_q[$past(wr_idx)] >= $past(conf_q[wr_idx])));
  // R2: a not-taken resolution never raises the counter
  a_r2_down_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken) |=> (conf_q[$past(wr_idx)] <= $past(conf_q[wr_idx])));
  // R9: counters stay still without a resolution
  a_r9_conf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(conf_q));
endmodule

// File: rtl/bp_tgt_cache.sv
module bp_tgt_cache #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_dest,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_dest
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PC_W-1:0]    dest_q [ENTRIES];
  logic [ENTRIES-1:0] slot_we;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign slot_we[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (slot_we[g]) begin
        tag_q[g]  <= wr_tag;
        dest_q[g] <= wr_dest;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_q | slot_we;
  end

  assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_dest = dest_q[rd_idx];

  // R1: reset empties the cache
  a_r1_cache_clear: assert property (@(posedge clk)
    !rst_n |=> (vld_q == '0));
  // R6: an install leaves the slot valid
  a_r6_install_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
  // R9: valid flags stay still without an install
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_npc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic [PC_W-1:0] upd_pred_npc,
  output logic            mispredict
);
  localparam int TAG_W   = PC_W - IDX_W - 2;
  localparam int IDX_LSB = 2;
  localparam int TAG_LSB = IDX_W + 2;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             f_dir_taken, f_hit;
  logic [PC_W-1:0]  f_dest, f_seq, u_seq, u_real_npc;

  assign f_idx = fetch_pc[IDX_LSB +: IDX_W];
  assign f_tag = fetch_pc[TAG_LSB +: TAG_W];
  assign u_idx = upd_pc[IDX_LSB +: IDX_W];
  assign u_tag = upd_pc[TAG_LSB +: TAG_W];
  assign f_seq = fetch_pc + PC_W'(4);
  assign u_seq = upd_pc + PC_W'(4);

  bp_dir_table #(.IDX_W(IDX_W)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (f_idx),
    .rd_taken (f_dir_taken),
    .wr_en    (upd_valid),
    .wr_idx   (u_idx),
    .wr_taken (upd_taken)
  );

  bp_tgt_cache #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (f_idx),
    .rd_tag  (f_tag),
    .rd_hit  (f_hit),
    .rd_dest (f_dest),
    .wr_en   (upd_valid && upd_taken),
    .wr_idx  (u_idx),
    .wr_tag  (u_tag),
    .wr_dest (upd_target)
  );

  assign pred_npc   = (f_hit && f_dir_taken) ? f_dest : f_seq;
  assign u_real_npc = upd_taken ? upd_target : u_seq;
  assign mispredict = upd_valid && (upd_pred_npc != u_real_npc);

  // R7: a flush is only requested alongside a resolution
  a_r7_flush_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> upd_valid);
  // R5: a redirect away from the sequential path needs a hit and a taken guess
  a_r5_redirect_source: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_npc != f_seq) |-> (f_hit && f_dir_taken));
endmodule

// File: tb/sim_branch_predictor.sv
`timescale 1ns/1ps
module sim_branch_predictor;
  localparam int PW = 32;
  localparam int IW = 3;
  localparam int N  = 1 << IW;
  localparam int TW = PW - IW - 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] fetch_pc, pred_npc, upd_pc, upd_target, upd_pred_npc;
  logic          upd_valid, upd_taken, mispredict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int            m_conf [N];
  bit            m_vld  [N];
  logic [TW-1:0] m_tag  [N];
  logic [PW-1:0] m_dest [N];

  always #2 clk = ~clk;

  branch_predictor #(.PC_W(PW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_npc(upd_pred_npc), .mispredict(mispredict)
  );

  function automatic logic [PW-1:0] mk_pc(int region, int slot);
    return (region != 0 ? 32'h0040_2000 : 32'h0000_1000) | PW'(slot << 2);
  endfunction

  function automatic logic [PW-1:0] model_pred(logic [PW-1:0] pc);
    int i;
    i = int'(pc[IW+1:2]);
    if (m_vld[i] && m_tag[i] == pc[PW-1:IW+2] && m_conf[i] >= 2) return m_dest[i];
    return pc + 32'd4;
  endfunction

  function automatic logic model_flush(logic v, logic [PW-1:0] pc, logic t,
                                       logic [PW-1:0] dst, logic [PW-1:0] pn);
    if (!v) return 1'b0;
    return pn != (t ? dst : pc + 32'd4);
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_conf[i] = 1; m_vld[i] = 1'b0; m_tag[i] = '0; m_dest[i] = '0;
    end
  endfunction

  function automatic void model_update(logic [PW-1:0] pc, logic t, logic [PW-1:0] dst);
    int i;
    i = int'(pc[IW+1:2]);
    if (t) begin
      if (m_conf[i] < 3) m_conf[i]++;
      m_vld[i] = 1'b1; m_tag[i] = pc[PW-1:IW+2]; m_dest[i] = dst;
    end else if (m_conf[i] > 0) m_conf[i]--;
  endfunction

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(string req, logic [PW-1:0] fpc, logic v, logic [PW-1:0] upc,
                     logic t, logic [PW-1:0] dst, logic [PW-1:0] pn);
    @(negedge clk);
    fetch_pc = fpc; upd_valid = v; upd_pc = upc;
    upd_taken = t; upd_target = dst; upd_pred_npc = pn;
    #1;
    chk({req, " pred_npc"}, pred_npc, model_pred(fpc));
    chk({req, " mispredict (R7)"}, PW'(mispredict), PW'(model_flush(v, upc, t, dst, pn)));
    @(posedge clk);
    if (v) model_update(upc, t, dst);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] a, b, d1, d2, fpc, upc, dst, pn;
    logic t, v;
    void'($urandom(32'd20240611));
    a = mk_pc(0, 5); b = mk_pc(1, 5);
    d1 = 32'h0000_8880; d2 = 32'h0000_8890;
    rst_n = 1'b0; fetch_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_target = '0; upd_pred_npc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty tables fall through everywhere
    for (int s = 0; s < N; s++) cyc("R1 reset", mk_pc(s & 1, s), 1'b0, '0, 1'b0, '0, '0);
    // R7 wrong direction, then R6 install and R5 redirect
    cyc("R7 direction", a, 1'b1, a, 1'b1, d1, a + 32'd4);
    cyc("R5 R6 installed", a, 1'b0, '0, 1'b0, '0, '0);
    // R4: same slot, other tag
    cyc("R4 tag mismatch", b, 1'b0, '0, 1'b0, '0, '0);
    // R8: lookup during update of the same slot sees old state
    cyc("R8 same slot", a, 1'b1, a, 1'b1, d1, d1);
    // R3: one not-taken from 11 keeps the taken guess
    cyc("R3 first miss", a, 1'b1, a, 1'b0, '0, d1);
    cyc("R3 still taken", a, 1'b0, '0, 1'b0, '0, '0);
    // R7: right direction, wrong destination
    cyc("R7 target", a, 1'b1, a, 1'b1, d2, d1);
    cyc("R6 new dest", a, 1'b0, '0, 1'b0, '0, '0);
    // R9: junk on the port without the strobe
    cyc("R9 idle port", a, 1'b0, a, 1'b0, 32'hDEAD_BEEC, 32'h1234_5678);
    cyc("R9 unchanged", a, 1'b0, '0, 1'b0, '0, '0);
    // R2/R8: two not-taken in a row, the second seen with old state
    cyc("R2 down", a, 1'b1, a, 1'b0, '0, d2);
    cyc("R8 old value", a, 1'b1, a, 1'b0, '0, d2);
    cyc("R3 flipped", a, 1'b0, '0, 1'b0, '0, '0);
    // R6: not-taken leaves the slot; saturation at 00 then recovery
    cyc("R2 floor", a, 1'b1, a, 1'b0, '0, a + 32'd4);
    cyc("R2 up from floor", a, 1'b1, a, 1'b1, d2, a + 32'd4);
    cyc("R2 R6 weak", a, 1'b0, '0, 1'b0, '0, '0);
    // R2: saturation at 11
    for (int k = 0; k < 5; k++) cyc("R2 ceiling", b, 1'b1, b, 1'b1, d1, b + 32'd4);
    cyc("R2 R4 retagged", a, 1'b0, '0, 1'b0, '0, '0);

    // Random mix over two aliasing regions (R2 R4 R5 R6 R7 R8 R9)
    for (int n = 0; n < 4000; n++) begin
      fpc = mk_pc(int'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)));
      upc = mk_pc(int'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)));
      v   = ($urandom_range(0, 3) != 0);
      t   = $urandom_range(0, 1) == 1;
      dst = {$urandom_range(0, 15) == 0 ? $urandom() : 32'h0000_8000 | ($urandom_range(0, 7) << 4)};
      dst[1:0] = 2'b00;
      pn  = ($urandom_range(0, 1) == 1) ? model_pred(upc) : ($urandom() & 32'hFFFF_FFFC);
      cyc("R2 R4 R5 R6 R7 R8 R9 random", fpc, v, upc, t, dst, pn);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule